// File: doc/BRIEF.md
# Triple-Redundant Trigger Voter with Upset Reporting

The block receives three redundant copies of a pattern-trigger result word on every bunch-crossing cycle (40 MHz in the target system) and produces one voted trigger word. The vote is a bitwise majority. Each cycle is graded by how badly the copies disagree. A cycle is clean when all three copies match. It is a single upset when exactly one copy is the odd one out. It is a double upset when no two copies are equal. A single upset still delivers the voted word and raises a warning. A double upset cannot be trusted, so the output word is forced to zero for that cycle.

Upset events are counted separately by severity. A free-running cycle counter provides a time stamp, and the stamp of the most recent event is kept. A remote trigger controller has two ways to learn about upsets. It can poll: a request returns a registered response that carries sticky "seen" flags. The block can also volunteer a report on its own: it gives a one-cycle pulse and holds a pending flag until the controller acknowledges it. A record port shows both counts and the last event stamp to the readout path at all times.

Top module: `tmr_trig_voter`

## Requirements
- R1: `trig_o` shows the bitwise majority of the three copies applied in the previous cycle. The output is registered, so latency is one cycle.
- R2: When exactly two copies are equal and the third differs, the voted word is output unchanged. `warn_o` is 1 and `dbl_o` is 0 in that output cycle.
- R3: When all three copies differ pairwise, `trig_o` is all zeros, `dbl_o` is 1 and `warn_o` is 0 in that output cycle.
- R4: When all three copies are equal, `trig_o` equals that word and both `warn_o` and `dbl_o` are 0.
- R5: `rec_sgl_cnt_o` counts single-upset cycles and `rec_dbl_cnt_o` counts double-upset cycles. Both are 16 bits and saturate at 16'hFFFF. `clear_i` zeroes both counters. An upset in the same cycle as `clear_i` is counted after the clear, so the counter becomes 1.
- R6: A 32-bit cycle counter starts at 0 when reset is released and increments on every clock edge. On each upset cycle, `rec_time_o` takes the counter value of that cycle. `clear_i` does not change `rec_time_o`.
- R7: A `poll_req_i` pulse gives `resp_valid_o` = 1 in the next cycle. `resp_flags_o` then carries the sticky flags from before the request cycle: bit 0 means a single upset was seen and bit 1 means a double upset was seen. The flags are cleared only by `clear_i`, and an upset in the same cycle as the clear sets its flag again.
- R8: With `vol_en_i` = 1, an upset cycle gives `vol_pulse_o` = 1 for exactly the next cycle and sets `vol_pend_o`. `vol_pend_o` stays at 1 until `vol_ack_i`. If an upset and an acknowledge happen in the same cycle, the flag stays set.
- R9: With `vol_en_i` = 0, upsets produce no pulse and do not set `vol_pend_o`. Counting and time stamping still take place.
- R10: After reset, `trig_o`, both flags, both counts, the stamp, the poll response and the volunteer outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| copy_a_i | input | 16 | Redundant trigger copy A |
| copy_b_i | input | 16 | Redundant trigger copy B |
| copy_c_i | input | 16 | Redundant trigger copy C |
| clear_i | input | 1 | Controller command: clear counters and sticky flags |
| poll_req_i | input | 1 | Controller poll request |
| vol_en_i | input | 1 | Enable volunteered reporting |
| vol_ack_i | input | 1 | Controller acknowledge of a volunteered report |
| trig_o | output | 16 | Voted trigger word |
| warn_o | output | 1 | Single upset in the voted cycle |
| dbl_o | output | 1 | Double upset in the voted cycle (word zeroed) |
| resp_valid_o | output | 1 | Poll response valid |
| resp_flags_o | output | 2 | Sticky flags {double seen, single seen} |
| vol_pulse_o | output | 1 | One-cycle volunteered upset notice |
| vol_pend_o | output | 1 | Volunteered notice awaiting acknowledge |
| rec_sgl_cnt_o | output | 16 | Saturating single-upset count |
| rec_dbl_cnt_o | output | 16 | Saturating double-upset count |
| rec_time_o | output | 32 | Cycle stamp of the latest upset |

## Verification
The assertions assume that every cycle carries a valid set of copies and that the controller inputs are plain synchronous levels. A poll request gets its response in the following cycle whether or not another request comes right behind it. The stimulus drives every input on the falling edge, so each value is stable over the active edge. Every copy set is built from a base word with chosen bits flipped, which gives known clean, single and double cases, including a double case where all three copies differ in different bits. The saturation run pushes single upsets past 65535 so that the hold at all ones is reached, then applies a clear together with an upset.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        UPS_NONE   = 2'd0,
        UPS_SINGLE = 2'd1,
        UPS_DOUBLE = 2'd2
    } ups_kind_e;
endpackage

// File: rtl/tmr_vote_core.sv
module tmr_vote_core
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] vote_o,
    output ups_kind_e    kind_o
);
    logic ab_eq, bc_eq, ac_eq;

    always_comb begin
        vote_o = (a_i & b_i) | (b_i & c_i) | (a_i & c_i);
        ab_eq  = (a_i == b_i);
        bc_eq  = (b_i == c_i);
        ac_eq  = (a_i == c_i);
        if (ab_eq && bc_eq)
            kind_o = UPS_NONE;
        else if (ab_eq || bc_eq || ac_eq)
            kind_o = UPS_SINGLE;
        else
            kind_o = UPS_DOUBLE;
    end
endmodule

// File: rtl/upset_recorder.sv
module upset_recorder
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int TS_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ups_kind_e        kind_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] sgl_cnt_o,
    output logic [CNT_W-1:0] dbl_cnt_o,
    output logic [TS_W-1:0]  last_ts_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] sgl;
        logic [CNT_W-1:0] dbl;
        logic [TS_W-1:0]  ts;
        logic [TS_W-1:0]  last;
    } rec_t;

    rec_t st_d, st_q;

    function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] cur,
                                              input logic hit, input logic clr);
        logic [CNT_W-1:0] base;
        base = clr ? '0 : cur;
        if (hit && base != CNT_MAX)
            return base + 1'b1;
        return base;
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.ts  = st_q.ts + 1'b1;
        st_d.sgl = bump(st_q.sgl, kind_i == UPS_SINGLE, clear_i);
        st_d.dbl = bump(st_q.dbl, kind_i == UPS_DOUBLE, clear_i);
        if (kind_i != UPS_NONE)
            st_d.last = st_q.ts;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sgl_cnt_o = st_q.sgl;
    assign dbl_cnt_o = st_q.dbl;
    assign last_ts_o = st_q.last;

    p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sgl_cnt_o == CNT_MAX && !clear_i) |=> sgl_cnt_o == CNT_MAX);
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && kind_i != UPS_DOUBLE) |=> dbl_cnt_o == '0);
    p_ts_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> st_q.ts == $past(st_q.ts) + 1'b1);
endmodule

// File: rtl/upset_notifier.sv
module upset_notifier
    import tmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  ups_kind_e kind_i,
    input  logic      clear_i,
    input  logic      poll_req_i,
    input  logic      vol_en_i,
    input  logic      vol_ack_i,
    output logic      resp_valid_o,
    output logic [1:0] resp_flags_o,
    output logic      vol_pulse_o,
    output logic      vol_pend_o
);
    typedef struct packed {
        logic [1:0] sticky;
        logic       rvalid;
        logic [1:0] rflags;
        logic       pulse;
        logic       pend;
    } ntf_t;

    ntf_t st_d, st_q;
    logic event_w;

    always_comb begin
        event_w   = (kind_i != UPS_NONE);
        st_d      = st_q;
        st_d.rvalid = poll_req_i;
        if (poll_req_i)
            st_d.rflags = st_q.sticky;
        if (clear_i)
            st_d.sticky = 2'b00;
        if (kind_i == UPS_SINGLE) st_d.sticky[0] = 1'b1;
        if (kind_i == UPS_DOUBLE) st_d.sticky[1] = 1'b1;
        st_d.pulse = event_w && vol_en_i;
        if (event_w && vol_en_i)
            st_d.pend = 1'b1;
        else if (vol_ack_i)
            st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign resp_valid_o = st_q.rvalid;
    assign resp_flags_o = st_q.rflags;
    assign vol_pulse_o  = st_q.pulse;
    assign vol_pend_o   = st_q.pend;

    p_poll_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req_i |=> resp_valid_o);
    p_pulse_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vol_pulse_o |-> vol_pend_o);
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !vol_en_i |=> !vol_pulse_o);
endmodule

// File: rtl/tmr_trig_voter.sv
module tmr_trig_voter
    import tmr_pkg::*;
#(
    parameter int W     = 16,
    parameter int CNT_W = 16,
    parameter int TS_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     copy_a_i,
    input  logic [W-1:0]     copy_b_i,
    input  logic [W-1:0]     copy_c_i,
    input  logic             clear_i,
    input  logic             poll_req_i,
    input  logic             vol_en_i,
    input  logic             vol_ack_i,
    output logic [W-1:0]     trig_o,
    output logic             warn_o,
    output logic             dbl_o,
    output logic             resp_valid_o,
    output logic [1:0]       resp_flags_o,
    output logic             vol_pulse_o,
    output logic             vol_pend_o,
    output logic [CNT_W-1:0] rec_sgl_cnt_o,
    output logic [CNT_W-1:0] rec_dbl_cnt_o,
    output logic [TS_W-1:0]  rec_time_o
);
    typedef struct packed {
        logic [W-1:0] word;
        logic         warn;
        logic         dbl;
    } out_t;

    out_t         out_d, out_q;
    logic [W-1:0] vote_w;
    ups_kind_e    kind_w;

    tmr_vote_core #(.W(W)) u_vote (
        .a_i(copy_a_i), .b_i(copy_b_i), .c_i(copy_c_i),
        .vote_o(vote_w), .kind_o(kind_w)
    );

    always_comb begin
        out_d.dbl  = (kind_w == UPS_DOUBLE);
        out_d.warn = (kind_w == UPS_SINGLE);
        out_d.word = out_d.dbl ? '0 : vote_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign trig_o = out_q.word;
    assign warn_o = out_q.warn;
    assign dbl_o  = out_q.dbl;

    upset_recorder #(.CNT_W(CNT_W), .TS_W(TS_W)) u_rec (
        .clk(clk), .rst_n(rst_n), .kind_i(kind_w), .clear_i(clear_i),
        .sgl_cnt_o(rec_sgl_cnt_o), .dbl_cnt_o(rec_dbl_cnt_o),
        .last_ts_o(rec_time_o)
    );

    upset_notifier u_ntf (
        .clk(clk), .rst_n(rst_n), .kind_i(kind_w), .clear_i(clear_i),
        .poll_req_i(poll_req_i), .vol_en_i(vol_en_i), .vol_ack_i(vol_ack_i),
        .resp_valid_o(resp_valid_o), .resp_flags_o(resp_flags_o),
        .vol_pulse_o(vol_pulse_o), .vol_pend_o(vol_pend_o)
    );

    p_dbl_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dbl_o |-> trig_o == '0);
    p_flag_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({warn_o, dbl_o}));
    p_clean_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_a_i == copy_b_i && copy_b_i == copy_c_i)
        |=> (trig_o == $past(copy_a_i) && !warn_o && !dbl_o));
endmodule

// File: tb/tmr_trig_voter_tb_top.sv
module tmr_trig_voter_tb_top;
    typedef struct {
        logic [15:0] word;
        logic        warn;
        logic        dbl;
        string       req;
    } exp_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] ca = 0, cb = 0, cc = 0;
    logic        clr = 0, preq = 0, ven = 0, vack = 0;
    logic [15:0] trig;
    logic        warn, dbl, rvalid, vpulse, vpend;
    logic [1:0]  rflags;
    logic [15:0] scnt, dcnt;
    logic [31:0] rtime;

    int total = 0, bad = 0;
    int edges = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    tmr_trig_voter dut_i (
        .clk(clk), .rst_n(rst_n), .copy_a_i(ca), .copy_b_i(cb), .copy_c_i(cc),
        .clear_i(clr), .poll_req_i(preq), .vol_en_i(ven), .vol_ack_i(vack),
        .trig_o(trig), .warn_o(warn), .dbl_o(dbl), .resp_valid_o(rvalid),
        .resp_flags_o(rflags), .vol_pulse_o(vpulse), .vol_pend_o(vpend),
        .rec_sgl_cnt_o(scnt), .rec_dbl_cnt_o(dcnt), .rec_time_o(rtime)
    );

    always @(posedge clk) if (rst_n) edges <= edges + 1;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops one expected vote result per cycle
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.req, {46'd0, e.word, e.warn, e.dbl}, {46'd0, trig, warn, dbl});
        end
    end

    // Driver: one cycle of copies; stamp = cycle counter seen this cycle
    task automatic step(input logic [15:0] a, b, c, input string req,
                        output int stamp);
        exp_t e;
        @(negedge clk);
        ca = a; cb = b; cc = c;
        stamp = edges;
        e.req = req;
        if (a == b && b == c) begin e.word = a; e.warn = 0; e.dbl = 0; end
        else if (a != b && b != c && a != c) begin e.word = 0; e.warn = 0; e.dbl = 1; end
        else begin e.word = (a & b) | (b & c) | (a & c); e.warn = 1; e.dbl = 0; end
        q.push_back(e);
        @(posedge clk); #2;
    endtask

    initial begin
        #1000000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int st, last;
        #12;
        // R10 reset state
        chk("R10", {trig, warn, dbl, rvalid, rflags, vpulse, vpend}, 0);
        chk("R10", {scnt, dcnt, rtime}, 0);
        @(negedge clk); rst_n = 1;

        // R4 / R1 clean words
        step(16'hA5A5, 16'hA5A5, 16'hA5A5, "R4", st);
        step(16'h0000, 16'h0000, 16'h0000, "R1", st);
        step(16'hFFFF, 16'hFFFF, 16'hFFFF, "R4", st);
        chk("R5", {scnt, dcnt}, 0);

        // R2 single upsets, each copy as the odd one; R6 stamp
        step(16'h1234, 16'h1234, 16'h9234, "R2", st);
        step(16'h00F0, 16'h0FF0, 16'h00F0, "R2", st);
        step(16'hBEEF, 16'h1EEF, 16'h1EEF, "R2", last);
        chk("R6", rtime, last);
        chk("R5", scnt, 3);

        // R3 double: pairwise different in distinct bits
        step(16'h0001, 16'h0002, 16'h0004, "R3", last);
        step(16'hFF00, 16'h0FF0, 16'h00FF, "R3", last);
        chk("R5", dcnt, 2);
        chk("R6", rtime, last);

        // R7 poll: sticky single+double seen
        @(negedge clk); preq = 1; ca = 0; cb = 0; cc = 0;
        @(posedge clk); #2; preq = 0;
        chk("R7", {rvalid, rflags}, 3'b111);
        @(posedge clk); #2;
        chk("R7", rvalid, 0);

        // R6 clear does not touch stamp; R5 clear zeroes; R7 flags cleared
        @(negedge clk); clr = 1;
        @(posedge clk); #2; clr = 0;
        chk("R5", {scnt, dcnt}, 0);
        chk("R6", rtime, last);
        @(negedge clk); preq = 1;
        @(posedge clk); #2; preq = 0;
        chk("R7", {rvalid, rflags}, 3'b100);

        // R9 volunteer disabled
        step(16'h0001, 16'h0001, 16'h0003, "R9", st);
        chk("R9", {vpulse, vpend}, 0);
        chk("R9", scnt, 1);

        // R8 volunteer enabled
        ven = 1;
        step(16'h0007, 16'h0005, 16'h0007, "R8", st);
        chk("R8", {vpulse, vpend}, 2'b11);
        step(16'h0007, 16'h0007, 16'h0007, "R8", st);
        chk("R8", {vpulse, vpend}, 2'b01);
        @(negedge clk); vack = 1;
        @(posedge clk); #2; vack = 0;
        chk("R8", vpend, 0);
        // ack together with a new upset: pending stays
        @(negedge clk); vack = 1; ca = 1; cb = 2; cc = 4;
        @(posedge clk); #2; vack = 0; ca = 0; cb = 0; cc = 0;
        chk("R8", {vpulse, vpend}, 2'b11);
        ven = 0;

        // R5 saturation
        for (int i = 0; i < 65540; i++) begin
            @(negedge clk); ca = 16'h0010; cb = 16'h0010; cc = 16'h0000;
        end
        @(posedge clk); #2;
        chk("R5", scnt, 16'hFFFF);
        // clear together with an upset counts to 1
        @(negedge clk); clr = 1;
        @(posedge clk); #2; clr = 0; ca = 0; cb = 0; cc = 0;
        chk("R5", scnt, 1);
        @(negedge clk); preq = 1;
        @(posedge clk); #2; preq = 0;
        chk("R7", {rvalid, rflags}, 3'b101);

        q.delete();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule